// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM. The host hands over one byte access at a time through a valid/ready handshake. The controller turns that access into strobe activity on the RAM pins: two chip selects of opposite polarity, an active-low write strobe, an active-low output enable, and an 8-bit data path. The chip-level pad cell merges the data path's drive value, drive enable and sampled input into the shared tri-state bus.

Each timing limit is a nanosecond parameter. It is turned into a whole number of clock cycles, always rounding up, so every minimum is met and every maximum is waited out. A retention input lets the system hold the RAM deselected while its supply is lowered. When that input is released, the controller refuses accesses until a recovery interval has passed.

Top module: `asram_port_ctl`

## Requirements
- R1: After reset, both selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: A write (`req_we`=1) holds `mem_we_n` low for exactly N_WP cycles. N_WP is the largest of ceil(WP), ceil(AW), ceil(CW) and ceil(DS)+1, which is 8 at the defaults. During the pulse both selects are active, `mem_oe_n` is 1 and `mem_addr` equals the request address.
- R3: `mem_dq_oe` is high only while `mem_we_n` is low and `mem_oe_n` is high. It never rises in the first cycle of the write pulse and falls in the same cycle that `mem_we_n` rises. It therefore drives `req_wdata` for N_WP-1 cycles, which is at least ceil(DS).
- R4: A write keeps `req_ready` low for max(ceil(WC), N_WP+1) cycles, which is 10 at the defaults.
- R5: A read holds `mem_oe_n` low with both selects active for N_RD = max(ceil(AA), ceil(ACS), ceil(OE)) cycles, which is 10. It samples `mem_dq_i` in the last of those cycles and presents the byte on `rd_data` with a single-cycle `rd_valid` pulse in the next cycle.
- R6: After `mem_oe_n` rises, a turnaround of N_TURN = max(ceil(HZ), ceil(RC)-N_RD, 1) cycles follows. That is 4 at the defaults. During it `req_ready` is low and `mem_dq_oe` stays 0, so a read keeps `req_ready` low for 14 cycles.
- R7: `req_ready` is low whenever an access is in progress. A request is taken only in a cycle with `req_valid` and `req_ready` both high. A request raised while the controller is busy is carried out once `req_ready` returns.
- R8: While `retain_req` is 1, in the same cycle, both selects are inactive, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `req_ready`=0. An access in flight is abandoned and produces no `rd_valid`.
- R9: After `retain_req` falls, `req_ready` stays low for exactly ceil(REC) cycles, counting the cycle in which it fell.
- R10: Every cycle count rounds its nanosecond limit up. For example, a 35 ns turn-off time at a 10 ns clock gives 4 turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host has an access to issue |
| req_ready | output | 1 | Controller can take an access this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle strobe, `rd_data` holds a read result |
| rd_data | output | 8 | Read result |
| retain_req | input | 1 | Hold the RAM in retention (deselected) |
| mem_addr | output | 17 | RAM address pins |
| mem_sel_n | output | 1 | Active-low RAM select |
| mem_sel | output | 1 | Active-high RAM select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 8 | Value to drive on the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Value sampled from the data bus |

## Verification
Two things can land on the same clock cycle. The retention input can rise while a read is still in its output-enable window, and it can also fall while the host already holds a request. The bench raises `retain_req` in the middle of a read. It then judges three things: the selects and `req_ready` drop in that very cycle, no `rd_valid` ever appears for the abandoned read, and the scoreboard queue stays empty. It then releases retention with a read request already waiting. That request must be served only after the exact recovery count, and its data must match the scoreboard.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WR    = 3'd1,
    PH_WTAIL = 3'd2,
    PH_RD    = 3'd3,
    PH_TURN  = 3'd4
  } phase_t;

  // nanoseconds to whole clock cycles, rounding up
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_fsm.sv
module asram_phase_fsm
  import asram_pkg::*;
#(
  parameter int N_WP    = 8,
  parameter int N_WTAIL = 2,
  parameter int N_RD    = 10,
  parameter int N_TURN  = 4,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_we,
  input  logic             abort,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             ph_last
);

  logic [CNT_W-1:0] ph_len;

  always_comb begin
    case (phase)
      PH_WR:    ph_len = CNT_W'(N_WP);
      PH_WTAIL: ph_len = CNT_W'(N_WTAIL);
      PH_RD:    ph_len = CNT_W'(N_RD);
      PH_TURN:  ph_len = CNT_W'(N_TURN);
      default:  ph_len = CNT_W'(1);
    endcase
  end

  assign ph_last = (cnt == ph_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) phase <= start_we ? PH_WR : PH_RD;
        end
        default: begin
          if (ph_last) begin
            cnt <= '0;
            case (phase)
              PH_WR:   phase <= PH_WTAIL;
              PH_RD:   phase <= PH_TURN;
              default: phase <= PH_IDLE;
            endcase
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (cnt < ph_len)) else $error("phase counter overran"); // R2
  AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WTAIL) |-> ($past(phase) == PH_WR || $past(phase) == PH_WTAIL))
    else $error("write tail without pulse"); // R4

endmodule

// File: rtl/asram_recovery.sv
module asram_recovery #(
  parameter int N_REC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retain,
  output logic hold
);

  localparam int REC_W = $clog2(N_REC + 1);

  logic [REC_W-1:0] rec_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             rec_cnt <= '0;
    else if (retain)        rec_cnt <= REC_W'(N_REC);
    else if (rec_cnt != '0) rec_cnt <= rec_cnt - REC_W'(1);
  end

  assign hold = retain || (rec_cnt != '0);

  AST_REC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(retain) |-> hold) else $error("recovery skipped"); // R9

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] din,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= fire;
      if (fire) rd_data <= din;
    end
  end

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid) else $error("read strobe longer than one cycle"); // R5

endmodule

// File: rtl/asram_port_ctl.sv
module asram_port_ctl
  import asram_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int WC_NS  = 100,
  parameter int AW_NS  = 80,
  parameter int CW_NS  = 80,
  parameter int WP_NS  = 60,
  parameter int DS_NS  = 40,
  parameter int RC_NS  = 100,
  parameter int AA_NS  = 100,
  parameter int ACS_NS = 100,
  parameter int OE_NS  = 50,
  parameter int HZ_NS  = 35,
  parameter int REC_NS = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              retain_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_WP    = imax(imax(ns2cyc(WP_NS, CLK_NS), ns2cyc(AW_NS, CLK_NS)),
                                imax(ns2cyc(CW_NS, CLK_NS), ns2cyc(DS_NS, CLK_NS) + 1));
  localparam int N_WTAIL = imax(1, ns2cyc(WC_NS, CLK_NS) - N_WP);
  localparam int N_RD    = imax(imax(ns2cyc(AA_NS, CLK_NS), ns2cyc(ACS_NS, CLK_NS)),
                                imax(ns2cyc(OE_NS, CLK_NS), 1));
  localparam int N_TURN  = imax(imax(ns2cyc(HZ_NS, CLK_NS), ns2cyc(RC_NS, CLK_NS) - N_RD), 1);
  localparam int N_REC   = imax(1, ns2cyc(REC_NS, CLK_NS));
  localparam int MAXLEN  = imax(imax(N_WP, N_WTAIL), imax(N_RD, N_TURN));
  localparam int CNT_W   = $clog2(MAXLEN + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             ph_last;
  logic             rec_hold;
  logic             accept;
  logic             wr_window;
  logic             rd_window;
  logic             rd_fire;
  logic [DATA_W-1:0] wdata_q;

  // named events used by the checks below
  assign accept    = req_valid && req_ready;
  assign wr_window = (phase == PH_WR) && !retain_req;
  assign rd_window = (phase == PH_RD) && !retain_req;
  assign rd_fire   = rd_window && ph_last;

  asram_phase_fsm #(
    .N_WP(N_WP), .N_WTAIL(N_WTAIL), .N_RD(N_RD), .N_TURN(N_TURN), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_we(req_we),
    .abort(retain_req), .phase(phase), .cnt(cnt), .ph_last(ph_last)
  );

  asram_recovery #(.N_REC(N_REC)) u_rec (
    .clk(clk), .rst_n(rst_n), .retain(retain_req), .hold(rec_hold)
  );

  asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .fire(rd_fire), .din(mem_dq_i),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      wdata_q  <= req_wdata;
    end
  end

  assign req_ready = (phase == PH_IDLE) && !rec_hold;
  assign mem_sel_n = !(wr_window || rd_window);
  assign mem_sel   = wr_window || rd_window;
  assign mem_we_n  = !wr_window;
  assign mem_oe_n  = !rd_window;
  // drive only after the strobe has fallen; release together with its rise
  assign mem_dq_oe = wr_window && (cnt != '0);
  assign mem_dq_o  = wdata_q;

  AST_DRIVE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && mem_sel && !mem_sel_n))
    else $error("bus driven outside write window"); // R3
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe) else $error("bus held after write strobe"); // R3
  AST_DRIVE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe) else $error("bus driven with strobe edge"); // R3
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> (!mem_dq_oe && !req_ready)) else $error("no read turnaround"); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe)) else $error("ready while busy"); // R7
  AST_RET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    retain_req |-> (mem_sel_n && !mem_sel && !req_ready)) else $error("selected in retention"); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$fell(mem_we_n)) |-> $stable(mem_addr)) else $error("address moved in write"); // R2

endmodule

// File: tb/asram_port_ctl_test.sv
module asram_port_ctl_test;

  localparam int CLK_NS = 10;
  localparam int REC_CYC = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        retain_req = 1'b0;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'h00;

  int checks = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  asram_port_ctl #(.CLK_NS(CLK_NS), .REC_NS(REC_CYC*CLK_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .retain_req(retain_req),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // RAM model and pin observers, all updated mid-cycle
  logic [7:0] sram [logic [16:0]];
  logic [7:0] ref_mem [logic [16:0]];
  logic [7:0] exp_q [$];
  int we_run = 0, last_we = 0, oe_run = 0, last_oe = 0, drv_run = 0, last_drv = 0;
  int since_oe = 100, viol_r3 = 0, viol_r6 = 0, viol_r2 = 0;
  logic [16:0] wr_addr_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && (mem_we_n || !mem_oe_n)) viol_r3++;
      if (mem_dq_oe && !mem_we_n && we_run == 0) viol_r3++;
      if (!mem_we_n && (mem_sel_n || !mem_sel || !mem_oe_n)) viol_r2++;
      if (!mem_we_n) wr_addr_seen = mem_addr;
      if (!mem_we_n) we_run++; else if (we_run != 0) begin last_we = we_run; we_run = 0; end
      if (mem_dq_oe) drv_run++; else if (drv_run != 0) begin last_drv = drv_run; drv_run = 0; end
      if (!mem_oe_n) begin oe_run++; since_oe = 0; end
      else begin
        if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
        since_oe++;
      end
      if (mem_dq_oe && since_oe <= 4) viol_r6++;   // R10: 35 ns rounds up to 4
      if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_oe) sram[mem_addr] = mem_dq_o;
      if (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
        mem_dq_i = sram.exists(mem_addr) ? sram[mem_addr] : 8'hA5;
      else
        mem_dq_i = 8'h00;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected rd_valid", int'(rd_data), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R5 read data", int'(rd_data), int'(e));
      end
    end
  end

  // issue one access; waits for ready, returns in the first busy cycle
  task automatic issue(input bit we, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (we) ref_mem[a] = d;
    else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'hA5);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 1;
    while (!req_ready) begin @(negedge clk); n++; end
    n--;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_sel_n && !mem_sel, "R1 selects", {mem_sel_n, mem_sel}, 2);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes", {mem_we_n, mem_oe_n, mem_dq_oe}, 6);
    chk(req_ready && !rd_valid, "R1 ready", {req_ready, rd_valid}, 2);

    // write
    issue(1'b1, 17'h1_2345, 8'h3C);
    busy_len(n);
    chk(n == 10, "R4 write busy", n, 10);
    @(negedge clk);
    chk(last_we == 8, "R2 write pulse", last_we, 8);
    chk(wr_addr_seen == 17'h1_2345, "R2 address", int'(wr_addr_seen), 'h12345);
    chk(last_drv == 7, "R3 drive length", last_drv, 7);

    // read back
    issue(1'b0, 17'h1_2345, 8'h00);
    busy_len(n);
    chk(n == 14, "R6 read busy with turnaround", n, 14);
    chk(last_oe == 10, "R5 OE window", last_oe, 10);

    // read then write raised while busy, then verify the write
    issue(1'b1, 17'h0_0000, 8'hFF);
    issue(1'b1, 17'h1_FFFF, 8'h81);
    issue(1'b0, 17'h0_0000, 8'h00);
    issue(1'b1, 17'h0_0000, 8'h5A);     // R7 held request while read busy
    issue(1'b0, 17'h0_0000, 8'h00);
    issue(1'b0, 17'h1_FFFF, 8'h00);
    busy_len(n);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all requests served", exp_q.size(), 0);

    // retention during a read
    issue(1'b0, 17'h1_2345, 8'h00);
    void'(exp_q.pop_back());            // abandoned read: no result expected
    repeat (3) @(negedge clk);
    chk(!mem_oe_n, "R5 read in progress", int'(mem_oe_n), 0);
    retain_req = 1'b1;
    #1;
    chk(mem_sel_n && !mem_sel && mem_oe_n, "R8 deselect same cycle",
        {mem_sel_n, mem_sel, mem_oe_n}, 5);
    chk(!req_ready, "R8 ready low", int'(req_ready), 0);
    repeat (6) @(negedge clk);
    retain_req = 1'b0;
    busy_len(n);
    chk(n == REC_CYC, "R9 recovery length", n, REC_CYC);

    // retention release with a request already waiting
    @(negedge clk);
    retain_req = 1'b1;
    @(negedge clk);
    retain_req = 1'b0;
    issue(1'b0, 17'h1_2345, 8'h00);
    busy_len(n);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 read after recovery", exp_q.size(), 0);

    chk(viol_r2 == 0, "R2 strobes during pulse", viol_r2, 0);
    chk(viol_r3 == 0, "R3 drive rule", viol_r3, 0);
    chk(viol_r6 == 0, "R6 R10 turnaround", viol_r6, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule